// File: doc/BRIEF.md
# Timing-Error Recovering Pipeline

This block is a short linear pipeline of `N_STAGES` registered stages. Each stage adds a fixed step to the word it receives and holds a valid bit. Every stage captures its result twice. The main copy is the early sample, and downstream logic uses it. The shadow copy is the late sample, and it is always the correct value. The late sample is modelled by capturing the true result. The early sample is that result XORed with a per-stage skew mask supplied on `skew_mask_i`, so a nonzero mask in a capture cycle models a setup violation. A valid stage whose two copies differ has a timing error.

A parameter selects one of two recovery schemes. In stall mode, any error freezes the whole pipeline for one cycle, and every erring stage reloads its main copy from its shadow. In counterflow mode, the oldest erring stage (the highest index) repairs itself from its shadow, and the stage after it receives a bubble. One cycle later the corrected value moves on. A flush train then walks backwards from the erring stage, clearing one upstream stage per cycle. When the train reaches the front, a one-cycle replay request reports how many valid operations were squashed, so that the front end can issue them again.

The front end must hold its request while `in_ready_o` is low. No result is lost or duplicated, and results leave in the order in which operations were accepted or replayed.

Top module: `razor_pipe`

## Requirements
- R1: After reset, `in_ready_o` is 1, and `out_valid_o`, `replay_valid_o` and `err_count_o` are 0.
- R2: With no skew, an operation accepted at a clock edge appears on `out_data_o` with `out_valid_o` high N_STAGES-1 edges later. Its value is the input plus the sum of 1..N_STAGES (stage s, counted from 0, adds s+1), and results keep their acceptance order.
- R3: `err_count_o` increases by the number of stages that show a detected mismatch in a cycle.
- R4: Stall mode: an error lowers `in_ready_o` for exactly one cycle, and every result still comes out correct, once, in order.
- R5: Counterflow mode: the erring operation continues with its shadow value and reaches the output with the correct result, exactly once.
- R6: Counterflow mode: after an error in stage k, `in_ready_o` is low for k+2 cycles (the detection cycle plus k+1 train cycles), and stages below k are cleared one per cycle, from k-1 down to 0.
- R7: Counterflow mode: one single-cycle `replay_valid_o` pulse per recovery, with `replay_cnt_o` equal to the number of valid operations squashed. Squashed operations never reach the output.
- R8: Counterflow mode: when several stages err in the same cycle, only the highest-index one is repaired. Younger erring operations are squashed with the rest and counted in `replay_cnt_o`.
- R9: `out_valid_o` is never high while the last stage's two copies differ. Whenever it is high, the output equals the last stage's shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Front end offers an operation |
| in_data_i | input | DATA_W | Operand of the offered operation |
| in_ready_o | output | 1 | Operation is accepted at the next edge when high |
| skew_mask_i | input | N_STAGES*DATA_W | Per-stage XOR applied to the early (main) sample; slice s covers stage s |
| out_valid_o | output | 1 | Result present this cycle |
| out_data_o | output | DATA_W | Result word |
| replay_valid_o | output | 1 | Single-cycle replay request |
| replay_cnt_o | output | $clog2(N_STAGES+1) | Number of squashed operations to reissue |
| err_count_o | output | CNT_W | Running count of detected mismatches |

## Verification
Both recovery modes are tested with dense back-to-back streams. Skew is placed on stage 0, on a middle stage, on the last stage, and on two stages in the same edge. Because the stream is dense, every upstream slot is occupied, so the replay count and the number of cycles with intake blocked separate a train that starts at the right stage from one that starts off by one. The last-stage case separates correct output gating from a leak of the early value. The paired-error case separates subsuming the younger error from repairing it twice. A clean stream and a single isolated operation fix the latency and the arithmetic, and they show that no cycle is lost when nothing goes wrong.

// File: rtl/razor_pkg.sv
package razor_pkg;
  typedef enum logic {
    REC_STALL       = 1'b0,
    REC_COUNTERFLOW = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/razor_stage.sv
module razor_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_vld_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic [DATA_W-1:0] skew_i,
  input  logic              fix_i,
  input  logic              frz_i,
  input  logic              clr_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] main_o,
  output logic [DATA_W-1:0] shad_o,
  output logic              err_o
);
  logic              vld_q;
  logic [DATA_W-1:0] main_q, shad_q, res;

  assign res = src_data_i + DATA_W'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      main_q <= '0;
      shad_q <= '0;
    end else if (fix_i) begin
      main_q <= shad_q;
    end else if (frz_i) begin
      if (clr_i) vld_q <= 1'b0;
    end else begin
      vld_q  <= src_vld_i;
      main_q <= res ^ skew_i;
      shad_q <= res;
    end
  end

  assign vld_o  = vld_q;
  assign main_o = main_q;
  assign shad_o = shad_q;
  assign err_o  = vld_q && (main_q != shad_q);

  assert_fix_from_shadow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |=> (main_q == $past(shad_q)) && !err_o);
  assert_frozen_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_i && !clr_i && !fix_i) |=> $stable(main_q) && $stable(vld_q));
  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fix_i) |=> !vld_q);
endmodule

// File: rtl/razor_ctrl.sv
module razor_ctrl
  import razor_pkg::*;
#(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned CNT_W    = 16,
  parameter rec_mode_e   RECOVERY = REC_COUNTERFLOW,
  localparam int unsigned PTR_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1,
  localparam int unsigned SQ_W    = $clog2(N_STAGES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] err_i,
  input  logic [N_STAGES-1:0] vld_i,
  output logic [N_STAGES-1:0] fix_o,
  output logic [N_STAGES-1:0] frz_o,
  output logic [N_STAGES-1:0] clr_o,
  output logic                det_o,
  output logic                in_ready_o,
  output logic                replay_valid_o,
  output logic [SQ_W-1:0]     replay_cnt_o,
  output logic [CNT_W-1:0]    err_count_o
);
  localparam bit IS_CF = (RECOVERY == REC_COUNTERFLOW);

  logic                rec_q;
  logic [PTR_W-1:0]    stage_q, ptr_q, oldest;
  logic [SQ_W-1:0]     sq_q;
  logic [CNT_W-1:0]    cnt_q, n_err;
  logic [N_STAGES-1:0] det_err;
  logic                det;

  // stages frozen behind an active train cannot raise a new detection
  always_comb begin
    det_err = '0;
    oldest  = '0;
    for (int s = 0; s < N_STAGES; s++) begin
      det_err[s] = err_i[s] && !(IS_CF && rec_q && (PTR_W'(s) < stage_q));
      if (det_err[s]) oldest = PTR_W'(s);
    end
  end

  assign det   = |det_err;
  assign n_err = CNT_W'($countones(det_err));

  always_comb begin
    for (int s = 0; s < N_STAGES; s++) begin
      if (IS_CF) begin
        fix_o[s] = det && (PTR_W'(s) == oldest);
        frz_o[s] = det ? (PTR_W'(s) < oldest) : (rec_q && (PTR_W'(s) < stage_q));
        clr_o[s] = !det && rec_q && (ptr_q != '0) && (PTR_W'(s) == ptr_q - PTR_W'(1));
      end else begin
        fix_o[s] = det_err[s];
        frz_o[s] = det;
        clr_o[s] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= 1'b0;
      stage_q <= '0;
      ptr_q   <= '0;
      sq_q    <= '0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + n_err;
      if (IS_CF && det) begin
        rec_q   <= 1'b1;
        stage_q <= oldest;
        ptr_q   <= oldest;
        if (!rec_q) sq_q <= '0;
      end else if (rec_q) begin
        if (ptr_q == '0) begin
          rec_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q - PTR_W'(1);
          sq_q  <= sq_q + SQ_W'(vld_i[ptr_q - PTR_W'(1)]);
        end
      end
    end
  end

  assign det_o          = det;
  assign in_ready_o     = !det && !rec_q;
  assign replay_valid_o = rec_q && (ptr_q == '0) && !det;
  assign replay_cnt_o   = sq_q;
  assign err_count_o    = cnt_q;

  assert_count_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det |=> (err_count_o != $past(err_count_o)));
  assert_replay_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |=> !replay_valid_o);
  assert_train_steps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q && !det && (ptr_q != '0)) |=> (ptr_q == $past(ptr_q) - PTR_W'(1)));
  assert_oldest_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fix_o) || !IS_CF);

  if (!IS_CF) begin : g_stall_chk
    assert_one_cycle_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      det |=> !det);
  end
endmodule

// File: rtl/razor_pipe.sv
module razor_pipe
  import razor_pkg::*;
#(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter rec_mode_e   RECOVERY = REC_COUNTERFLOW,
  localparam int unsigned SQ_W    = $clog2(N_STAGES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [DATA_W-1:0]          in_data_i,
  output logic                       in_ready_o,
  input  logic [N_STAGES*DATA_W-1:0] skew_mask_i,
  output logic                       out_valid_o,
  output logic [DATA_W-1:0]          out_data_o,
  output logic                       replay_valid_o,
  output logic [SQ_W-1:0]            replay_cnt_o,
  output logic [CNT_W-1:0]           err_count_o
);
  logic [N_STAGES-1:0] vld, err, fix, frz, clr, src_vld;
  logic [DATA_W-1:0]   main_w [N_STAGES];
  logic [DATA_W-1:0]   shad_w [N_STAGES];
  logic [DATA_W-1:0]   src_w  [N_STAGES];
  logic                det;

  razor_ctrl #(
    .N_STAGES(N_STAGES), .CNT_W(CNT_W), .RECOVERY(RECOVERY)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .err_i(err), .vld_i(vld),
    .fix_o(fix), .frz_o(frz), .clr_o(clr), .det_o(det),
    .in_ready_o, .replay_valid_o, .replay_cnt_o, .err_count_o
  );

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign src_vld[s] = in_valid_i && in_ready_o;
      assign src_w[s]   = in_data_i;
    end else begin : g_body
      // a repairing or frozen predecessor hands on a bubble
      assign src_vld[s] = vld[s-1] && !frz[s-1] && !fix[s-1];
      assign src_w[s]   = main_w[s-1];
    end

    razor_stage #(.DATA_W(DATA_W), .STEP(s + 1)) i_stage (
      .clk_i, .rst_ni,
      .src_vld_i(src_vld[s]), .src_data_i(src_w[s]),
      .skew_i(skew_mask_i[s*DATA_W +: DATA_W]),
      .fix_i(fix[s]), .frz_i(frz[s]), .clr_i(clr[s]),
      .vld_o(vld[s]), .main_o(main_w[s]), .shad_o(shad_w[s]), .err_o(err[s])
    );
  end

  assign out_valid_o = vld[N_STAGES-1] && !err[N_STAGES-1] && !((RECOVERY == REC_STALL) && det);
  assign out_data_o  = main_w[N_STAGES-1];

  assert_out_clean_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o == shad_w[N_STAGES-1]));
  assert_no_intake_in_repair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_valid_o |-> !in_ready_o);
endmodule

// File: tb/test_razor_pipe.sv
module test_razor_pipe;
  import razor_pkg::*;
  localparam int N = 4;
  localparam int W = 16;
  localparam int SUM = N * (N + 1) / 2;
  localparam int SQ = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           in_valid = 1'b0, in_ready, out_valid, rp_valid;
  logic [W-1:0]   in_data = '0, out_data;
  logic [N*W-1:0] skew = '0;
  logic [SQ-1:0]  rp_cnt;
  logic [15:0]    err_cnt;

  logic           s_in_valid = 1'b0, s_in_ready, s_out_valid, s_rp_valid;
  logic [W-1:0]   s_in_data = '0, s_out_data;
  logic [N*W-1:0] s_skew = '0;
  logic [SQ-1:0]  s_rp_cnt;
  logic [15:0]    s_err_cnt;

  razor_pipe #(.N_STAGES(N), .DATA_W(W), .CNT_W(16), .RECOVERY(REC_COUNTERFLOW)) i_razor_pipe (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .skew_mask_i(skew), .out_valid_o(out_valid),
    .out_data_o(out_data), .replay_valid_o(rp_valid), .replay_cnt_o(rp_cnt),
    .err_count_o(err_cnt));

  razor_pipe #(.N_STAGES(N), .DATA_W(W), .CNT_W(16), .RECOVERY(REC_STALL)) i_razor_pipe_stall (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(s_in_valid), .in_data_i(s_in_data),
    .in_ready_o(s_in_ready), .skew_mask_i(s_skew), .out_valid_o(s_out_valid),
    .out_data_o(s_out_data), .replay_valid_o(s_rp_valid), .replay_cnt_o(s_rp_cnt),
    .err_count_o(s_err_cnt));

  logic [W-1:0] exp_q[$], replay_q[$], s_exp_q[$];
  int n_chk = 0, n_err = 0;
  string cur_req = "R2";
  int ready_low = 0, s_ready_low = 0, rp_pulses = 0, last_rp = -1, s_rp_pulses = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitors: scoreboard pops on every result, replay drops the youngest entries
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk({cur_req, " unexpected result"}, int'(out_data), -1);
        else chk(cur_req, int'(out_data), int'(exp_q.pop_front()));
      end
      if (rp_valid) begin
        rp_pulses++;
        last_rp = int'(rp_cnt);
        for (int i = 0; i < int'(rp_cnt); i++)
          if (exp_q.size() > 0) replay_q.push_front(exp_q.pop_back() - W'(SUM));
      end
      if (!in_ready) ready_low++;
      if (s_out_valid) begin
        if (s_exp_q.size() == 0) chk("R4 unexpected result", int'(s_out_data), -1);
        else chk("R4", int'(s_out_data), int'(s_exp_q.pop_front()));
      end
      if (s_rp_valid) s_rp_pulses++;
      if (!s_in_ready) s_ready_low++;
    end
  end

  task automatic send(logic [W-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(d + W'(SUM));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic s_send(logic [W-1:0] d);
    s_in_valid = 1'b1;
    s_in_data  = d;
    while (!s_in_ready) @(negedge clk);
    s_exp_q.push_back(d + W'(SUM));
    @(negedge clk);
    s_in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 60 && (exp_q.size() > 0 || s_exp_q.size() > 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({cur_req, " leftover"}, exp_q.size() + s_exp_q.size(), 0);
  endtask

  // skew set at the d-th negedge hits the op entering each marked stage at the next edge
  task automatic cf_burst(int n, int base, int d, logic [N-1:0] stages);
    fork
      for (int i = 0; i < n; i++) send(W'(base + i));
      begin
        if (stages != '0) begin
          repeat (d) @(negedge clk);
          for (int s = 0; s < N; s++) if (stages[s]) skew[s*W +: W] = 16'h00a5;
          @(negedge clk);
          skew = '0;
        end
      end
    join
    while (replay_q.size() > 0) send(replay_q.pop_front());
    drain();
  endtask

  task automatic st_burst(int n, int base, int d, logic [N-1:0] stages);
    fork
      for (int i = 0; i < n; i++) s_send(W'(base + i));
      begin
        repeat (d) @(negedge clk);
        for (int s = 0; s < N; s++) if (stages[s]) s_skew[s*W +: W] = 16'h0f0f;
        @(negedge clk);
        s_skew = '0;
      end
    join
    drain();
  endtask

  task automatic cf_case(string req, int base, logic [N-1:0] stages, int e_err, int e_rp, int e_low);
    int err0;
    cur_req = req;
    err0 = int'(err_cnt);
    ready_low = 0;
    rp_pulses = 0;
    last_rp = -1;
    cf_burst(8, base, 5, stages);
    chk({req, " R3 error count"}, int'(err_cnt) - err0, e_err);
    chk({req, " R7 replay pulses"}, rp_pulses, 1);
    chk({req, " R7 replay count"}, last_rp, e_rp);
    chk({req, " R6 intake blocked cycles"}, ready_low, e_low);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int err0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 replay_valid", int'(rp_valid), 0);
    chk("R1 err_count", int'(err_cnt), 0);
    chk("R1 stall err_count", int'(s_err_cnt), 0);

    // R2: latency of an isolated op
    cur_req = "R2";
    send(16'd5);
    repeat (N - 2) @(negedge clk);
    chk("R2 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid after N-1 edges", int'(out_valid), 1);
    drain();

    // R2: clean dense stream, no blocked cycles
    ready_low = 0;
    cf_burst(8, 100, 0, '0);
    chk("R2 no blocked cycles", ready_low, 0);
    chk("R2 no errors", int'(err_cnt), 0);

    // R5/R6/R7: middle stage, stages 0..1 squashed
    cf_case("R5 stage2", 200, 4'b0100, 1, 2, 4);
    // R6: first stage, nothing upstream
    cf_case("R6 stage0", 300, 4'b0001, 1, 0, 2);
    // R9: last stage mismatch must not leak
    cf_case("R9 stage3", 400, 4'b1000, 1, 3, 5);
    // R8: two errors in one edge, younger subsumed
    cf_case("R8 stages1+3", 500, 4'b1010, 2, 3, 5);

    // R4: stall mode
    cur_req = "R4";
    err0 = int'(s_err_cnt);
    s_ready_low = 0;
    st_burst(8, 600, 5, 4'b0100);
    chk("R4 one stall cycle", s_ready_low, 1);
    chk("R4 R3 error count", int'(s_err_cnt) - err0, 1);
    err0 = int'(s_err_cnt);
    s_ready_low = 0;
    st_burst(8, 700, 5, 4'b1010);
    chk("R4 paired errors one stall", s_ready_low, 1);
    chk("R4 R3 paired error count", int'(s_err_cnt) - err0, 2);
    chk("R4 no replay in stall mode", s_rp_pulses, 0);

    finish_run();
  end
endmodule